// File: doc/BRIEF.md
# Multiplexed RGB LED panel scanner

This block refreshes a tiled tri-colour LED panel. The panel is built from constant-current sink drivers that take their grayscale data serially. The panel has 36 rows and 32 columns. It is cut into twelve segments of 16 columns by 6 rows, six on each half. Each segment has one serial input that feeds three cascaded 16-channel drivers: red is the first driver in the cascade, green the second and blue the third. A separate calibration string is not multiplexed. It has its own serial input and shares the serial clock and the latch strobe.

The scanner reads grayscale words from a frame buffer port. One read returns a word for every lane (twelve segments plus the calibration string) at a given row, colour and channel. The scanner shifts one row's data into all lanes in parallel on a shared serial clock. When the load is complete and the current row's slot has ended, it blanks the drivers, switches the anode rows off, pulses the latch, enables the next row and releases blank. It then runs a fixed number of grayscale clocks. Like-numbered rows of all segments share one of six one-hot row enables. Every lit slot has the same length, so each row gets an equal share of the on time. The next row is shifted while the current row is lit. When that shift is late, the panel stays dark until the latch, so no row is lit longer than its slot.

Top module: `led_scan_top`

## Requirements
- R1: While reset is high, and in the first cycle after it: `row_en` is 0, `drv_blank` is 1, and `drv_latch`, `drv_sclk`, `drv_gsclk`, `fb_rd_en` and all serial data outputs are 0.
- R2: Each row load gives every segment lane 3·NCOL·GSW rising edges of `drv_sclk`. The word order is blue, then green, then red. Within a colour the channels run from NCOL-1 down to 0, and each word is sent MSB first. The frame buffer colour code is 0 for red, 1 for green and 2 for blue. `fb_rd_data` arrives one cycle after the `fb_rd_en` strobe, and segment s uses bits [s·GSW +: GSW]. Serial data is stable at each rising edge of `drv_sclk`.
- R3: The calibration lane (`cal_sdata`) takes bits [NSEG·GSW +: GSW] of the same reads. It is shifted in the same order and on the same clock edges as the segment lanes.
- R4: `drv_latch` is a single-cycle pulse. It occurs only while `drv_blank` is 1, `row_en` is 0 and `drv_sclk` is 0, and only after a complete load.
- R5: Rows are lit in the order 0, 1, …, NROW-1, 0, … . Row i is lit with the data of the load for row i. Its enable (`row_en` bit i) rises one cycle after the latch pulse.
- R6: Every lit interval (`drv_blank` low) lasts exactly 2·PWM_CLKS cycles and holds exactly PWM_CLKS rising edges of `drv_gsclk`. `drv_gsclk` is 0 whenever `drv_blank` is 1.
- R7: Between the end of a lit interval and the next latch, `drv_blank` stays 1 and `row_en` stays 0, however long the load takes.
- R8: `row_en` has at most one bit set. It changes only while `drv_blank` is 1. While `drv_blank` is 0, exactly one bit is set.
- R9: `drv_mode` is held at 0, which selects grayscale data.
- R10: After reset, no row is enabled and blank stays 1 until the first full row has been latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Frame buffer read strobe |
| fb_rd_row | output | RW | Row within segment for the read |
| fb_rd_color | output | 2 | Colour for the read (0 red, 1 green, 2 blue) |
| fb_rd_chan | output | CW | Driver channel for the read |
| fb_rd_data | input | (NSEG+1)·GSW | Read data, one GSW-bit word per lane, one cycle after the strobe |
| drv_sclk | output | 1 | Shared serial clock |
| drv_sdata | output | NSEG | Serial data, one bit per segment string |
| cal_sdata | output | 1 | Serial data for the calibration string |
| drv_latch | output | 1 | Shared latch strobe |
| drv_blank | output | 1 | Shared blank, high turns outputs off |
| drv_gsclk | output | 1 | Shared grayscale PWM clock |
| drv_mode | output | 1 | Driver data mode select, held low |
| row_en | output | NROW | One-hot anode row enables |

## Verification
The bench model treats each rising edge of `drv_sclk` as the moment a serial bit is due. It samples all lanes in that same cycle and compares them with the word the model reads at that point of the blue-green-red, high-channel-first, MSB-first order. Read data is modelled as returning one cycle after the strobe, so a late capture moves every bit. At each latch pulse the model requires exactly 3·NCOL·GSW edges since the previous latch. It then expects the matching row enable in the next cycle and the fall of blank one cycle after that. Blank must rise again exactly 2·PWM_CLKS cycles later, after PWM_CLKS grayscale rises. All sampling is done at the falling clock edge, so each registered output is read in the cycle it becomes valid.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  // Colour code on the frame buffer port
  typedef enum logic [1:0] {
    CLR_RED = 2'd0,
    CLR_GRN = 2'd1,
    CLR_BLU = 2'd2
  } color_e;

  typedef enum logic [2:0] {
    SQ_BOOT,
    SQ_WAIT,
    SQ_LATCH,
    SQ_ENA,
    SQ_LIT
  } seq_st_e;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_RD,
    SH_CAP,
    SH_SET,
    SH_RISE
  } sh_st_e;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/led_chain_loader.sv
module led_chain_loader
  import led_scan_pkg::*;
#(
  parameter int NLANE = 13,
  parameter int NROW  = 6,
  parameter int NCOL  = 16,
  parameter int GSW   = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [bits_for(NROW)-1:0]   row_in,
  output logic                        done,
  output logic                        fb_rd_en,
  output logic [bits_for(NROW)-1:0]   fb_rd_row,
  output logic [1:0]                  fb_rd_color,
  output logic [bits_for(NCOL)-1:0]   fb_rd_chan,
  input  logic [NLANE*GSW-1:0]        fb_rd_data,
  output logic                        sclk,
  output logic [NLANE-1:0]            sdata
);

  localparam int RW = bits_for(NROW);
  localparam int CW = bits_for(NCOL);
  localparam int BW = bits_for(GSW);

  sh_st_e          st_q;
  logic [RW-1:0]   row_q;
  color_e          col_q;
  logic [CW-1:0]   chan_q;
  logic [BW-1:0]   bit_q;
  logic            rd_en_q;
  logic            sclk_q;
  logic            done_q;
  logic            cap_en;
  logic            shift_en;
  logic            last_bit;
  logic            last_word;

  assign last_bit  = (bit_q == BW'(GSW - 1));
  assign last_word = (col_q == CLR_RED) && (chan_q == '0);
  assign cap_en    = (st_q == SH_CAP);
  assign shift_en  = (st_q == SH_RISE) && !last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SH_IDLE;
      row_q   <= '0;
      col_q   <= CLR_BLU;
      chan_q  <= CW'(NCOL - 1);
      bit_q   <= '0;
      rd_en_q <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SH_IDLE: begin
          if (start) begin
            row_q   <= row_in;
            col_q   <= CLR_BLU;
            chan_q  <= CW'(NCOL - 1);
            rd_en_q <= 1'b1;
            st_q    <= SH_RD;
          end
        end
        SH_RD: begin
          rd_en_q <= 1'b0;
          st_q    <= SH_CAP;
        end
        SH_CAP: begin
          bit_q <= '0;
          st_q  <= SH_SET;
        end
        SH_SET: begin
          sclk_q <= 1'b1;
          st_q   <= SH_RISE;
        end
        SH_RISE: begin
          sclk_q <= 1'b0;
          if (!last_bit) begin
            bit_q <= bit_q + 1'b1;
            st_q  <= SH_SET;
          end else if (last_word) begin
            done_q <= 1'b1;
            st_q   <= SH_IDLE;
          end else begin
            if (chan_q == '0) begin
              chan_q <= CW'(NCOL - 1);
              col_q  <= color_e'(2'(col_q) - 2'd1);
            end else begin
              chan_q <= chan_q - 1'b1;
            end
            rd_en_q <= 1'b1;
            st_q    <= SH_RD;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  // One shift register per lane; all lanes move together
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [GSW-1:0] sh_q;
    logic           bit_out_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q      <= '0;
        bit_out_q <= 1'b0;
      end else if (cap_en) begin
        bit_out_q <= fb_rd_data[l*GSW + GSW - 1];
        sh_q      <= fb_rd_data[l*GSW +: GSW] << 1;
      end else if (shift_en) begin
        bit_out_q <= sh_q[GSW-1];
        sh_q      <= sh_q << 1;
      end
    end
    assign sdata[l] = bit_out_q;
  end

  assign done        = done_q;
  assign fb_rd_en    = rd_en_q;
  assign fb_rd_row   = row_q;
  assign fb_rd_color = col_q;
  assign fb_rd_chan  = chan_q;
  assign sclk        = sclk_q;

endmodule

// File: rtl/led_row_sequencer.sv
module led_row_sequencer
  import led_scan_pkg::*;
#(
  parameter int NROW     = 6,
  parameter int PWM_CLKS = 4096
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_done,
  output logic                      load_start,
  output logic [bits_for(NROW)-1:0] load_row,
  output logic [NROW-1:0]           row_en,
  output logic                      blank,
  output logic                      latch,
  output logic                      gsclk
);

  localparam int RW   = bits_for(NROW);
  localparam int LIT  = 2 * PWM_CLKS;
  localparam int CTW  = bits_for(LIT);

  seq_st_e          st_q;
  logic             start_q;
  logic [RW-1:0]    row_q;
  logic [NROW-1:0]  row_en_q;
  logic             blank_q;
  logic             latch_q;
  logic             gsclk_q;
  logic [CTW-1:0]   cyc_q;
  logic             ready_q;
  logic [RW-1:0]    row_nxt;
  logic [NROW-1:0]  row_hot;

  assign row_nxt = (row_q == RW'(NROW - 1)) ? '0 : row_q + 1'b1;
  assign row_hot = {{(NROW-1){1'b0}}, 1'b1} << row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_BOOT;
      start_q  <= 1'b0;
      row_q    <= '0;
      row_en_q <= '0;
      blank_q  <= 1'b1;
      latch_q  <= 1'b0;
      gsclk_q  <= 1'b0;
      cyc_q    <= '0;
      ready_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      latch_q <= 1'b0;
      if (load_done) ready_q <= 1'b1;
      case (st_q)
        SQ_BOOT: begin
          start_q <= 1'b1;
          st_q    <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (ready_q) begin
            ready_q <= 1'b0;
            latch_q <= 1'b1;
            st_q    <= SQ_LATCH;
          end
        end
        SQ_LATCH: begin
          row_en_q <= row_hot;
          row_q    <= row_nxt;
          start_q  <= 1'b1;
          st_q     <= SQ_ENA;
        end
        SQ_ENA: begin
          blank_q <= 1'b0;
          gsclk_q <= 1'b0;
          cyc_q   <= '0;
          st_q    <= SQ_LIT;
        end
        SQ_LIT: begin
          if (cyc_q == CTW'(LIT - 1)) begin
            blank_q  <= 1'b1;
            row_en_q <= '0;
            gsclk_q  <= 1'b0;
            st_q     <= SQ_WAIT;
          end else begin
            gsclk_q <= ~gsclk_q;
            cyc_q   <= cyc_q + 1'b1;
          end
        end
        default: st_q <= SQ_WAIT;
      endcase
    end
  end

  assign load_start = start_q;
  assign load_row   = row_q;
  assign row_en     = row_en_q;
  assign blank      = blank_q;
  assign latch      = latch_q;
  assign gsclk      = gsclk_q;

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int NSEG     = 12,
  parameter int NROW     = 6,
  parameter int NCOL     = 16,
  parameter int GSW      = 12,
  parameter int PWM_CLKS = 4096
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic                          fb_rd_en,
  output logic [bits_for(NROW)-1:0]     fb_rd_row,
  output logic [1:0]                    fb_rd_color,
  output logic [bits_for(NCOL)-1:0]     fb_rd_chan,
  input  logic [(NSEG+1)*GSW-1:0]       fb_rd_data,
  output logic                          drv_sclk,
  output logic [NSEG-1:0]               drv_sdata,
  output logic                          cal_sdata,
  output logic                          drv_latch,
  output logic                          drv_blank,
  output logic                          drv_gsclk,
  output logic                          drv_mode,
  output logic [NROW-1:0]               row_en
);

  localparam int NLANE = NSEG + 1;
  localparam int RW    = bits_for(NROW);

  logic             ld_start;
  logic             ld_done;
  logic [RW-1:0]    ld_row;
  logic [NLANE-1:0] lane_bits;

  led_row_sequencer #(
    .NROW     (NROW),
    .PWM_CLKS (PWM_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load_done  (ld_done),
    .load_start (ld_start),
    .load_row   (ld_row),
    .row_en     (row_en),
    .blank      (drv_blank),
    .latch      (drv_latch),
    .gsclk      (drv_gsclk)
  );

  led_chain_loader #(
    .NLANE (NLANE),
    .NROW  (NROW),
    .NCOL  (NCOL),
    .GSW   (GSW)
  ) u_load (
    .clk         (clk),
    .rst         (rst),
    .start       (ld_start),
    .row_in      (ld_row),
    .done        (ld_done),
    .fb_rd_en    (fb_rd_en),
    .fb_rd_row   (fb_rd_row),
    .fb_rd_color (fb_rd_color),
    .fb_rd_chan  (fb_rd_chan),
    .fb_rd_data  (fb_rd_data),
    .sclk        (drv_sclk),
    .sdata       (lane_bits)
  );

  assign drv_sdata = lane_bits[NSEG-1:0];
  assign cal_sdata = lane_bits[NSEG];
  assign drv_mode  = 1'b0;

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
  parameter int NSEG     = 12,
  parameter int NROW     = 6,
  parameter int PWM_CLKS = 4096
) (
  input logic            clk,
  input logic            rst,
  input logic [NROW-1:0] row_en,
  input logic            drv_blank,
  input logic            drv_latch,
  input logic            drv_sclk,
  input logic            drv_gsclk,
  input logic [NSEG-1:0] drv_sdata,
  input logic            cal_sdata
);

  localparam int LIT = 2 * PWM_CLKS;

  logic [31:0] lit_cnt;
  logic        seen_latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      lit_cnt    <= '0;
      seen_latch <= 1'b0;
    end else begin
      lit_cnt <= drv_blank ? '0 : lit_cnt + 1;
      if (drv_latch) seen_latch <= 1'b1;
    end
  end

  // R2
  sdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_sclk) |-> $stable({cal_sdata, drv_sdata}));

  // R4
  latch_dark_chk: assert property (@(posedge clk) disable iff (rst)
    drv_latch |-> (drv_blank && row_en == '0 && !drv_sclk));

  // R4
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    drv_latch |=> !drv_latch);

  // R6
  lit_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_blank) |-> (lit_cnt == LIT));

  // R6
  lit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lit_cnt <= LIT);

  // R6
  gs_dark_chk: assert property (@(posedge clk) disable iff (rst)
    drv_blank |-> !drv_gsclk);

  // R8
  row_hot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en));

  // R8
  row_lit_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_blank |-> $countones(row_en) == 1);

  // R8
  row_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_en) |-> drv_blank);

  // R10
  boot_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_latch |-> (row_en == '0 && drv_blank));

endmodule

bind led_scan_top led_scan_chk #(
  .NSEG     (NSEG),
  .NROW     (NROW),
  .PWM_CLKS (PWM_CLKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .row_en    (row_en),
  .drv_blank (drv_blank),
  .drv_latch (drv_latch),
  .drv_sclk  (drv_sclk),
  .drv_gsclk (drv_gsclk),
  .drv_sdata (drv_sdata),
  .cal_sdata (cal_sdata)
);

// File: tb/led_scan_top_tb.sv
module led_scan_top_tb;

  localparam int NSEG  = 12;
  localparam int NROW  = 6;
  localparam int NCOL  = 4;
  localparam int GSW   = 4;
  localparam int PWMC  = 16;
  localparam int RW    = 3;
  localparam int CW    = 2;
  localparam int TOTAL = 3 * NCOL * GSW;
  localparam int LIT   = 2 * PWMC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic                    fb_rd_en;
  logic [RW-1:0]           fb_rd_row;
  logic [1:0]              fb_rd_color;
  logic [CW-1:0]           fb_rd_chan;
  logic [(NSEG+1)*GSW-1:0] fb_rd_data;
  logic                    drv_sclk, cal_sdata, drv_latch, drv_blank, drv_gsclk, drv_mode;
  logic [NSEG-1:0]         drv_sdata;
  logic [NROW-1:0]         row_en;

  always #2 clk = ~clk;

  led_scan_top #(
    .NSEG(NSEG), .NROW(NROW), .NCOL(NCOL), .GSW(GSW), .PWM_CLKS(PWMC)
  ) u_dut (
    .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_rd_row(fb_rd_row),
    .fb_rd_color(fb_rd_color), .fb_rd_chan(fb_rd_chan), .fb_rd_data(fb_rd_data),
    .drv_sclk(drv_sclk), .drv_sdata(drv_sdata), .cal_sdata(cal_sdata),
    .drv_latch(drv_latch), .drv_blank(drv_blank), .drv_gsclk(drv_gsclk),
    .drv_mode(drv_mode), .row_en(row_en)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [GSW-1:0] pix(input int r, input int c, input int ch, input int l);
    logic [31:0] v;
    v = r * 53 + c * 29 + ch * 7 + l * 13 + (r + l) * (ch + 3);
    return v[GSW-1:0];
  endfunction

  // Behavioural frame buffer with one cycle of read latency
  always @(posedge clk) begin
    if (fb_rd_en) begin
      for (int l = 0; l <= NSEG; l++)
        fb_rd_data[l*GSW +: GSW] <= pix(int'(fb_rd_row), int'(fb_rd_color), int'(fb_rd_chan), l);
    end
  end

  // Reference model state
  int  bit_k = 0, ld_row = 0, exp_lit = 0, lit_cnt = 0, gs_rise = 0;
  int  lits = 0, latches = 0;
  bit  prev_sclk = 0, prev_blank = 1, prev_gs = 0, seen = 0, in_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (drv_sclk && !prev_sclk) begin
        logic [NSEG-1:0] ev;
        logic [GSW-1:0]  wd;
        logic            ec;
        int w, b, c, ch;
        w  = bit_k / GSW;
        b  = GSW - 1 - (bit_k % GSW);
        c  = 2 - (w / NCOL);
        ch = NCOL - 1 - (w % NCOL);
        for (int l = 0; l < NSEG; l++) begin
          wd = pix(ld_row, c, ch, l);
          ev[l] = wd[b];
        end
        wd = pix(ld_row, c, ch, NSEG);
        ec = wd[b];
        chk(bit_k < TOTAL, "R2", "serial edges per load", bit_k + 1, TOTAL);
        chk(drv_sdata == ev, "R2", "segment serial bits", drv_sdata, ev);
        chk(cal_sdata == ec, "R3", "calibration serial bit", cal_sdata, ec);
        bit_k++;
      end
      if (drv_latch) begin
        chk(drv_blank && row_en == '0 && !drv_sclk, "R4", "latch while dark",
            {drv_blank, row_en, drv_sclk}, {1'b1, 6'b0, 1'b0});
        chk(bit_k == TOTAL, "R7", "latch only after full load", bit_k, TOTAL);
        exp_lit = ld_row;
        ld_row  = (ld_row + 1) % NROW;
        bit_k   = 0;
        seen    = 1;
        in_gap  = 0;
        latches++;
      end
      if (!drv_blank && prev_blank) begin
        chk(row_en == NROW'(1 << exp_lit), "R5", "row enabled after its latch",
            row_en, 1 << exp_lit);
        lit_cnt = 0;
        gs_rise = 0;
      end
      if (!drv_blank) begin
        lit_cnt++;
        if (drv_gsclk && !prev_gs) gs_rise++;
        chk(row_en == NROW'(1 << exp_lit), "R8", "single row while lit", row_en, 1 << exp_lit);
      end
      if (drv_blank && !prev_blank) begin
        chk(lit_cnt == LIT, "R6", "lit interval cycles", lit_cnt, LIT);
        chk(gs_rise == PWMC, "R6", "grayscale clocks per slot", gs_rise, PWMC);
        lits++;
        in_gap = 1;
      end
      if (drv_blank)
        chk(!drv_gsclk, "R6", "grayscale clock idle while blanked", drv_gsclk, 0);
      if (in_gap)
        chk(drv_blank && row_en == '0, "R7", "dark while waiting for load",
            {drv_blank, row_en}, {1'b1, 6'b0});
      if (!seen)
        chk(drv_blank && row_en == '0, "R10", "dark before first latch",
            {drv_blank, row_en}, {1'b1, 6'b0});
      chk(drv_mode == 1'b0, "R9", "mode select", drv_mode, 0);
      prev_sclk  = drv_sclk;
      prev_blank = drv_blank;
      prev_gs    = drv_gsclk;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(row_en == '0 && drv_blank && !drv_latch && !drv_sclk && !drv_gsclk && !fb_rd_en
        && drv_sdata == '0 && !cal_sdata, "R1", "outputs in reset",
        {row_en, drv_blank, drv_latch, drv_sclk, drv_gsclk, fb_rd_en},
        {6'b0, 1'b1, 4'b0});
    rst = 1'b0;
    @(negedge clk);
    chk(row_en == '0 && drv_blank && !drv_latch && !drv_sclk, "R1", "first cycle after reset",
        {row_en, drv_blank, drv_latch, drv_sclk}, {6'b0, 1'b1, 2'b0});
    cyc = 0;
    while (lits < 2 * NROW + 1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 20000, "R5", "watchdog: rows keep cycling", cyc, 20000);
    chk(latches >= 2 * NROW, "R5", "latches over two frames", latches, 2 * NROW);
    chk(ld_row == (latches % NROW), "R5", "row order wraps", ld_row, latches % NROW);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule